// File: doc/BRIEF.md
# Event-Triggered Programmable Pulse Outputs

This block sits behind a link decoder that presents one 8-bit event code per clock cycle. Each code indexes a 256-entry lookup table whose entries are 14-bit output masks. A set bit starts the matching pulse output. A started output first waits out a programmed delay, counted in whole clock cycles. It then drives a pulse of programmed length. The pulse sense is set by a per-output polarity bit.

All settings come in through one write-only configuration port. This covers the lookup entries and each output's delay, width, enable and polarity. Delays use a 27-bit cycle count, so at a 119 MHz clock the reach is a little over one second. Timing finer than one clock cycle is not part of this block. The block is used to fan a broadcast event stream out to a set of hardware triggers, each with its own timing.

Top module: `evt_pulse_bank`

## Requirements
- R1: After reset every output is low, every lookup entry is zero and every output is disabled with delay 0, width 0 and polarity 0.
- R2: A write with cfg_addr[8]=1 stores cfg_wdata[13:0] as the mask of code cfg_addr[7:0]. A write with cfg_addr[8]=0 targets output cfg_addr[5:2] and field cfg_addr[1:0]. Field 0 is delay (cfg_wdata[26:0]), field 1 is width (cfg_wdata[15:0]), and field 2 is control (cfg_wdata[0] enable, cfg_wdata[1] polarity). Writes to field 3, to output numbers 14 and 15, or with cfg_addr[7:6] nonzero change nothing.
- R3: A code sampled on a clock edge starts output i only when bit i of its lookup mask is 1 and output i is enabled. A zero mask starts nothing.
- R4: If a code that starts an output is sampled on edge t and the delay is D, the output shows its active level from edge t+D. With D=0 this is the edge that samples the code.
- R5: A pulse holds the active level for exactly W clock cycles, W being the width. With W=0 the output never leaves its inactive level.
- R6: The inactive level of an output equals its polarity bit, and the active level is its inverse. A polarity write changes the level on the following cycle.
- R7: A start that arrives while the output is waiting or pulsing ends any pulse at once and restarts the delay from the programmed value.
- R8: A disabled output holds its inactive level from the cycle after the disabling write. It ignores starts and abandons any wait or pulse in progress.
- R9: One code may start several outputs, and each then runs on its own delay and width.
- R10: All 27 delay bits take part in the count. A delay above 65535 cycles produces its pulse after exactly that many cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one delay step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_code | input | 8 | Event code sampled every cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | Configuration address (see R2) |
| cfg_wdata | input | 27 | Configuration write data |
| trig_out | output | 14 | Pulse outputs, one per channel |

## Verification
The hardest situation to reach is a new start landing on an output that is already busy, either mid-wait or mid-pulse. This gets harder when the same edge also carries a configuration write that disables the output or changes its mapping. Directed sequences place a restart inside a wait and inside a pulse, and a disable inside a wait. A random phase then drives dense code traffic over short delays and widths, with occasional write collisions in the same cycle. A directed run with a delay above 16 bits confirms that the upper counter bits take part.

// File: rtl/evt_pulse_pkg.sv
package evt_pulse_pkg;

  typedef enum logic [1:0] {CH_IDLE, CH_WAIT, CH_FIRE} ch_state_t;

  localparam int FLD_DELAY = 0;
  localparam int FLD_WIDTH = 1;
  localparam int FLD_CTRL  = 2;

  // Decode of a per-output configuration write: map bit clear, unused
  // upper bits zero, output number and field both matching.
  function automatic logic cfg_hits(input logic we, input logic [31:0] addr,
                                    input int code_w, input int ch_w,
                                    input int ch, input int fld);
    logic [31:0] lo;
    logic [31:0] chn;
    lo  = addr & ((32'd1 << code_w) - 32'd1);
    chn = (lo >> 2) & ((32'd1 << ch_w) - 32'd1);
    return we && (addr[code_w] == 1'b0) && (lo[1:0] == fld[1:0]) &&
           (chn == ch[31:0]) && ((lo >> (ch_w + 2)) == 32'd0);
  endfunction

  // Pin level from polarity, pulse state and enable.
  function automatic logic pin_level(input logic pol, input logic pulsing,
                                     input logic en);
    return pol ^ (pulsing & en);
  endfunction

endpackage

// File: rtl/evt_code_map.sv
module evt_code_map #(
  parameter int CODE_W  = 8,
  parameter int NUM_OUT = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CODE_W-1:0]  wr_code,
  input  logic [NUM_OUT-1:0] wr_mask,
  input  logic [CODE_W-1:0]  rd_code,
  output logic [NUM_OUT-1:0] rd_mask
);
  localparam int CODES = 1 << CODE_W;

  logic [NUM_OUT-1:0] mem [CODES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CODES; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_code] <= wr_mask;
    end
  end

  assign rd_mask = mem[rd_code];

  // R2: a mapping write is visible at its code on the next cycle
  a_r2_map_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_code)] == $past(wr_mask));

endmodule

// File: rtl/evt_pulse_chan.sv
module evt_pulse_chan
  import evt_pulse_pkg::*;
#(
  parameter int DLY_W = 27,
  parameter int WID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_delay,
  input  logic             wr_width,
  input  logic             wr_ctrl,
  input  logic [DLY_W-1:0] wdata,
  output logic             trig
);
  localparam int CNT_W = (DLY_W > WID_W) ? DLY_W : WID_W;

  logic [DLY_W-1:0] dly_q;
  logic [WID_W-1:0] wid_q;
  logic             en_q, pol_q;
  ch_state_t        st, st_d;
  logic [CNT_W-1:0] cnt, cnt_d;

  // named internal events
  logic start_ok, wait_expire, pulse_last, active;
  assign start_ok    = start & en_q;
  assign wait_expire = (st == CH_WAIT) && (cnt == CNT_W'(1));
  assign pulse_last  = (st == CH_FIRE) && (cnt == CNT_W'(1));
  assign active      = (st == CH_FIRE);

  always_comb begin
    st_d  = st;
    cnt_d = cnt;
    if (!en_q) begin
      st_d  = CH_IDLE;
      cnt_d = '0;
    end else if (start_ok) begin
      if (dly_q != '0) begin
        st_d  = CH_WAIT;
        cnt_d = CNT_W'(dly_q);
      end else if (wid_q != '0) begin
        st_d  = CH_FIRE;
        cnt_d = CNT_W'(wid_q);
      end else begin
        st_d  = CH_IDLE;
        cnt_d = '0;
      end
    end else begin
      case (st)
        CH_WAIT: begin
          if (wait_expire) begin
            st_d  = (wid_q != '0) ? CH_FIRE : CH_IDLE;
            cnt_d = CNT_W'(wid_q);
          end else begin
            cnt_d = cnt - CNT_W'(1);
          end
        end
        CH_FIRE: begin
          if (pulse_last) begin
            st_d  = CH_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt - CNT_W'(1);
          end
        end
        default: begin
          st_d  = CH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= CH_IDLE;
      cnt   <= '0;
      dly_q <= '0;
      wid_q <= '0;
      en_q  <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      if (wr_delay) dly_q <= wdata;
      if (wr_width) wid_q <= wdata[WID_W-1:0];
      if (wr_ctrl) begin
        en_q  <= wdata[0];
        pol_q <= wdata[1];
      end
      st  <= st_d;
      cnt <= cnt_d;
    end
  end

  assign trig = pin_level(pol_q, active, en_q);

  // R8: a disabled channel drops out of any wait or pulse
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !active);

  // R4: zero delay enters the pulse straight from the sampling edge
  a_r4_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && dly_q == '0 && wid_q != '0) |=>
      (active && cnt == CNT_W'($past(wid_q))));

  // R4: the wait counts down one per cycle while inactive
  a_r4_wait_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CH_WAIT && cnt > CNT_W'(1) && !start_ok && en_q) |=>
      (st == CH_WAIT && cnt == $past(cnt) - CNT_W'(1)));

  // R5: zero width skips the pulse after the wait
  a_r5_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_expire && wid_q == '0 && !start_ok && en_q) |=> !active);

  // R5: the last pulse cycle returns the channel to idle
  a_r5_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_last && !start_ok && en_q) |=> (st == CH_IDLE));

  // R7: a start with nonzero delay always reloads the full delay
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && dly_q != '0) |=>
      (st == CH_WAIT && !active && cnt == CNT_W'($past(dly_q))));

endmodule

// File: rtl/evt_pulse_bank.sv
module evt_pulse_bank
  import evt_pulse_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int NUM_OUT = 14,
  parameter int DLY_W   = 27,
  parameter int WID_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  evt_code,
  input  logic               cfg_we,
  input  logic [CODE_W:0]    cfg_addr,
  input  logic [DLY_W-1:0]   cfg_wdata,
  output logic [NUM_OUT-1:0] trig_out
);
  localparam int CH_W   = $clog2(NUM_OUT);
  localparam int ADDR_W = CODE_W + 1;

  logic [31:0]        addr32;
  logic               map_we;
  logic [NUM_OUT-1:0] start_mask;

  assign addr32 = {{(32 - ADDR_W){1'b0}}, cfg_addr};
  assign map_we = cfg_we & cfg_addr[CODE_W];

  evt_code_map #(.CODE_W(CODE_W), .NUM_OUT(NUM_OUT)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (map_we),
    .wr_code (cfg_addr[CODE_W-1:0]),
    .wr_mask (cfg_wdata[NUM_OUT-1:0]),
    .rd_code (evt_code),
    .rd_mask (start_mask)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_ch
    evt_pulse_chan #(.DLY_W(DLY_W), .WID_W(WID_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_mask[g]),
      .wr_delay (cfg_hits(cfg_we, addr32, CODE_W, CH_W, g, FLD_DELAY)),
      .wr_width (cfg_hits(cfg_we, addr32, CODE_W, CH_W, g, FLD_WIDTH)),
      .wr_ctrl  (cfg_hits(cfg_we, addr32, CODE_W, CH_W, g, FLD_CTRL)),
      .wdata    (cfg_wdata),
      .trig     (trig_out[g])
    );
  end

endmodule

// File: tb/evt_pulse_bank_tb.sv
module evt_pulse_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_code = 8'h00;
  logic        cfg_we = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [26:0] cfg_wdata = '0;
  logic [13:0] trig_out;

  always #5 clk = ~clk;

  evt_pulse_bank u_dut (
    .clk(clk), .rst_n(rst_n), .evt_code(evt_code), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .trig_out(trig_out)
  );

  // bench model: each output keeps an absolute window [ms, me) of edges
  logic [26:0] mdly [14];
  logic [15:0] mwid [14];
  bit          men  [14];
  bit          mpol [14];
  longint      ms   [14];
  longint      me   [14];
  logic [13:0] mmap [256];
  longint      n = 0;

  int  vectors = 0;
  int  errors  = 0;
  bit  done    = 1'b0;
  byte codes [24];

  initial begin
    for (int i = 0; i < 14; i++) begin
      mdly[i] = '0; mwid[i] = '0; men[i] = 0; mpol[i] = 0; ms[i] = 0; me[i] = 0;
    end
    for (int c = 0; c < 256; c++) mmap[c] = '0;
  end

  function automatic bit exp_pin(int i);
    bit inside_win;
    inside_win = (n >= ms[i]) && (n < me[i]);
    if (men[i] && inside_win) return !mpol[i];
    return mpol[i];
  endfunction

  task automatic model_edge();
    logic [13:0] hits;
    n++;
    hits = mmap[evt_code];
    for (int i = 0; i < 14; i++) begin
      if (!men[i]) begin
        ms[i] = 0; me[i] = 0;
      end else if (hits[i]) begin
        ms[i] = n + longint'(mdly[i]);
        me[i] = ms[i] + longint'(mwid[i]);
      end
    end
    if (cfg_we) begin
      if (cfg_addr[8]) mmap[cfg_addr[7:0]] = cfg_wdata[13:0];
      else if (cfg_addr[7:6] == 2'b00 && cfg_addr[5:2] < 4'd14) begin
        case (cfg_addr[1:0])
          2'd0: mdly[cfg_addr[5:2]] = cfg_wdata;
          2'd1: mwid[cfg_addr[5:2]] = cfg_wdata[15:0];
          2'd2: begin
            men[cfg_addr[5:2]]  = cfg_wdata[0];
            mpol[cfg_addr[5:2]] = cfg_wdata[1];
          end
          default: ;
        endcase
      end
    end
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < 14; i++) begin
      bit e;
      e = exp_pin(i);
      vectors++;
      if (trig_out[i] !== e) begin
        errors++;
        $display("FAIL %s cycle %0d out %0d: got %b expected %b", tag, n, i, trig_out[i], e);
      end
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ticks(int k, string tag);
    for (int j = 0; j < k; j++) tick(tag);
  endtask

  task automatic cfg(logic [8:0] a, logic [26:0] d, string tag);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(tag);
    cfg_we = 1'b0;
  endtask

  function automatic logic [8:0] ch_addr(int ch, int fld);
    return {3'b000, ch[3:0], fld[1:0]};
  endfunction

  function automatic logic [8:0] map_addr(logic [7:0] c);
    return {1'b1, c};
  endfunction

  task automatic fire(logic [7:0] c, string tag);
    evt_code = c;
    tick(tag);
    evt_code = 8'h00;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: outputs low while in reset and after release
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      compare("R1");
    end
    rst_n = 1'b1;
    evt_code = 8'h11;
    ticks(4, "R1");
    // R3: every code reads a zero mask, nothing starts
    evt_code = 8'hFF;
    ticks(3, "R3");
    evt_code = 8'h00;

    // R6: polarity 1 while disabled idles high
    cfg(ch_addr(3, 2), 27'd2, "R6");
    ticks(2, "R6");
    // R2: ignored writes: output 14, field 3, upper address bits set
    cfg(ch_addr(14, 2), 27'd3, "R2");
    cfg(ch_addr(0, 3), 27'd3, "R2");
    cfg({3'b001, 4'd0, 2'd2}, 27'd3, "R2");
    ticks(2, "R2");

    // R4: zero delay, width 3 on output 0
    cfg(ch_addr(0, 0), 27'd0, "R4");
    cfg(ch_addr(0, 1), 27'd3, "R4");
    cfg(ch_addr(0, 2), 27'd1, "R4");
    cfg(map_addr(8'h21), 27'h0001, "R4");
    fire(8'h21, "R4");
    ticks(6, "R4");

    // R9: one code drives output 1 (delay 5, width 2) and output 2 (delay 2, width 4, inverted)
    cfg(ch_addr(1, 0), 27'd5, "R9");
    cfg(ch_addr(1, 1), 27'd2, "R9");
    cfg(ch_addr(1, 2), 27'd1, "R9");
    cfg(ch_addr(2, 0), 27'd2, "R9");
    cfg(ch_addr(2, 1), 27'd4, "R9");
    cfg(ch_addr(2, 2), 27'd3, "R9");
    cfg(map_addr(8'h22), 27'h0006, "R9");
    fire(8'h22, "R9");
    ticks(12, "R9");

    // R5: width 0 never pulses
    cfg(ch_addr(4, 0), 27'd1, "R5");
    cfg(ch_addr(4, 1), 27'd0, "R5");
    cfg(ch_addr(4, 2), 27'd1, "R5");
    cfg(map_addr(8'h23), 27'h0010, "R5");
    fire(8'h23, "R5");
    ticks(4, "R5");

    // R7: restart inside a wait, then inside a pulse
    fire(8'h22, "R7");
    ticks(3, "R7");
    fire(8'h22, "R7");
    ticks(10, "R7");
    fire(8'h22, "R7");
    ticks(4, "R7");
    fire(8'h22, "R7");
    ticks(10, "R7");

    // R8: disable output 2 during its wait, then start it while disabled
    fire(8'h22, "R8");
    cfg(ch_addr(2, 2), 27'd2, "R8");
    ticks(8, "R8");
    fire(8'h22, "R8");
    ticks(8, "R8");
    cfg(ch_addr(2, 2), 27'd3, "R8");
    ticks(2, "R8");

    // R10: delay beyond 16 bits on output 13
    cfg(ch_addr(13, 0), 27'd70000, "R10");
    cfg(ch_addr(13, 1), 27'd2, "R10");
    cfg(ch_addr(13, 2), 27'd1, "R10");
    cfg(map_addr(8'h30), 27'h2000, "R10");
    fire(8'h30, "R10");
    ticks(70004, "R10");

    // R3: random configuration and dense random traffic
    for (int i = 0; i < 14; i++) begin
      cfg(ch_addr(i, 0), 27'($urandom_range(0, 20)), "R3");
      cfg(ch_addr(i, 1), 27'($urandom_range(0, 8)), "R3");
      cfg(ch_addr(i, 2), 27'({1'($urandom_range(0, 1)), 1'($urandom_range(0, 99) < 85)}), "R3");
    end
    for (int k = 0; k < 24; k++) begin
      codes[k] = byte'($urandom_range(1, 255));
      cfg(map_addr(codes[k]), 27'($urandom_range(0, 16383)), "R3");
    end
    for (int t = 0; t < 4000; t++) begin
      if ($urandom_range(0, 99) < 60) evt_code = codes[$urandom_range(0, 23)];
      else evt_code = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 99) < 3) begin
        cfg_we = 1'b1;
        case ($urandom_range(0, 2))
          0: begin
            cfg_addr  = ch_addr($urandom_range(0, 13), 0);
            cfg_wdata = 27'($urandom_range(0, 20));
          end
          1: begin
            cfg_addr  = ch_addr($urandom_range(0, 13), 2);
            cfg_wdata = 27'($urandom_range(0, 3));
          end
          default: begin
            cfg_addr  = map_addr(codes[$urandom_range(0, 23)]);
            cfg_wdata = 27'($urandom_range(0, 16383));
          end
        endcase
      end
      tick("R3");
      cfg_we = 1'b0;
    end
    evt_code = 8'h00;
    ticks(30, "R3");

    done = 1'b1;
    report();
    $finish;
  end

endmodule